// File: doc/BRIEF.md
# Dual-Clock Burst-Addressed Byte-Lane RAM

A true dual-port synchronous memory whose two ports each run on their own clock. Both ports can read or write any word, including the same word at the same time. Every address, control and write-data input is captured on the rising edge of its own port clock. Each word holds `LANES` lanes of `LANE_W` bits. With the defaults, that is 18 bits in two 9-bit lanes, and each lane has its own active-low enable.

Each port holds its address in a counter. The counter can be cleared, loaded from the address pins, stepped by one, or held. A processor or DMA engine can therefore give one start address and then stream a burst of words by asserting only the count enable.

A port takes part in an access only while its low-active select is low and its high-active select is high. A static mode pin on each port picks the read latency: one cycle for flow-through or two cycles for pipelined. Read data leave the block as a data word plus a per-lane drive-enable vector, so a pad ring or bus mux can build the tri-state from them.

`ADDR_W` sets the depth. A value of 13 gives 8K words. The default of 12 gives the 4K arrangement, in which the top pin address bit goes unused.

Top module: `dpr_burst_ram`

## Requirements
- R1: While a port's `rst_*_n` is low at its clock edge, that port's address counter, pending request and output stages are cleared. After reset, `rdata_*_en` is all zero and `rdata_*` is zero until the first read.
- R2: A selected write (`we_*_n` = 0) updates only the lanes whose `lane_*_n` bit is 0, and leaves the other lanes unchanged. Bit 0 controls data bits 8:0 and bit 1 controls bits 17:9.
- R3: The port is selected only when `cs_*_n` = 0 and `cs_*` = 1. A deselected cycle writes nothing, and two edges later in flow-through mode it leaves `rdata_*_en` all zero.
- R4: With `pipe_*` = 0, read data for an address registered at edge k appear after edge k+1.
- R5: With `pipe_*` = 1, the same read data appear one edge later, after edge k+2.
- R6: With `cnt_clr_*_n` high and `ads_*_n` low, the counter loads `addr_*` at the edge.
- R7: With `cnt_clr_*_n` and `ads_*_n` high, the counter steps up by one when `cnt_en_*_n` is low and holds when it is high.
- R8: `cnt_clr_*_n` low forces the counter to zero at the edge, whatever `ads_*_n` and `cnt_en_*_n` are.
- R9: A step from the highest address (all ones) wraps the counter to zero.
- R10: A lane's bit in `rdata_*_en` is high only for a selected read (`we_*_n` = 1) with `oe_*_n` = 0 and that lane's `lane_*_n` bit = 0. Any lane not enabled reads as zero on `rdata_*`.
- R11: A word written through one port reads back through the other port. This holds per lane and on any address the two ports do not hit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a_n | input | 1 | Port A synchronous reset, active low |
| addr_a | input | ADDR_W | Port A external address |
| ads_a_n | input | 1 | Port A address load strobe, active low |
| cnt_en_a_n | input | 1 | Port A counter step enable, active low |
| cnt_clr_a_n | input | 1 | Port A counter clear, active low |
| cs_a_n | input | 1 | Port A select, active low |
| cs_a | input | 1 | Port A select, active high |
| we_a_n | input | 1 | Port A write (0) / read (1) |
| lane_a_n | input | LANES | Port A lane enables, active low |
| oe_a_n | input | 1 | Port A output enable, active low |
| pipe_a | input | 1 | Port A latency mode: 0 flow-through, 1 pipelined |
| wdata_a | input | LANES*LANE_W | Port A write data |
| rdata_a | output | LANES*LANE_W | Port A read data |
| rdata_a_en | output | LANES | Port A per-lane drive enable |
| clk_b | input | 1 | Port B clock |
| rst_b_n | input | 1 | Port B synchronous reset, active low |
| addr_b | input | ADDR_W | Port B external address |
| ads_b_n | input | 1 | Port B address load strobe, active low |
| cnt_en_b_n | input | 1 | Port B counter step enable, active low |
| cnt_clr_b_n | input | 1 | Port B counter clear, active low |
| cs_b_n | input | 1 | Port B select, active low |
| cs_b | input | 1 | Port B select, active high |
| we_b_n | input | 1 | Port B write (0) / read (1) |
| lane_b_n | input | LANES | Port B lane enables, active low |
| oe_b_n | input | 1 | Port B output enable, active low |
| pipe_b | input | 1 | Port B latency mode: 0 flow-through, 1 pipelined |
| wdata_b | input | LANES*LANE_W | Port B write data |
| rdata_b | output | LANES*LANE_W | Port B read data |
| rdata_b_en | output | LANES | Port B per-lane drive enable |

## Verification
The bench builds the block with `ADDR_W` = 4 and keeps the default of two 9-bit lanes. With a 16-word space, a burst crosses the all-ones address within a few cycles, so counter wrap is reached directly. A random phase of a few hundred cycles also revisits every word often from both ports. That produces read-after-write across ports, same-cycle cross-port collisions, which the model marks as don't-care, and latency-mode switches over a shared, densely reused address range.

// File: rtl/dpr_pkg.sv
// Shared definitions for the dual-clock burst RAM.
// Assumes: nothing beyond IEEE 1800-2017.
package dpr_pkg;

    // Read latency selected by a port's static mode pin.
    typedef enum logic {
        LAT_FLOW = 1'b0,
        LAT_PIPE = 1'b1
    } lat_mode_e;

    localparam int DEF_ADDR_W = 12;
    localparam int DEF_LANE_W = 9;
    localparam int DEF_LANES  = 2;

endpackage

// File: rtl/dpr_port_ctrl.sv
// Port front-end: the address counter (which is the port's address
// register) plus registered write/read lane requests and write data.
// Assumes: every input is synchronous to clk; reset is synchronous, active low.
// Clear outranks load, load outranks step.
module dpr_port_ctrl #(
    parameter int ADDR_W = dpr_pkg::DEF_ADDR_W,
    parameter int LANE_W = dpr_pkg::DEF_LANE_W,
    parameter int LANES  = dpr_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              ads_n,
    input  logic              cnt_en_n,
    input  logic              cnt_clr_n,
    input  logic              cs_n,
    input  logic              cs,
    input  logic              we_n,
    input  logic [LANES-1:0]  lane_n,
    input  logic              oe_n,
    input  logic [WORD_W-1:0] wdata,
    output logic [ADDR_W-1:0] cur_addr,
    output logic [LANES-1:0]  wr_lanes,
    output logic [LANES-1:0]  rd_lanes,
    output logic [WORD_W-1:0] wr_data
);

    logic selected;

    assign selected = !cs_n && cs;

    // Address counter: clear, load, step or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
        end else if (!cnt_clr_n) begin
            cur_addr <= '0;
        end else if (!ads_n) begin
            cur_addr <= addr;
        end else if (!cnt_en_n) begin
            cur_addr <= cur_addr + 1'b1;
        end
    end

    // Request register: which lanes this cycle writes or drives out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_lanes <= '0;
            rd_lanes <= '0;
            wr_data  <= '0;
        end else begin
            wr_lanes <= (selected && !we_n) ? ~lane_n : '0;
            rd_lanes <= (selected && we_n && !oe_n) ? ~lane_n : '0;
            wr_data  <= wdata;
        end
    end

endmodule

// File: rtl/dpr_xor_lane_ram.sv
// One lane of true dual-port storage with a clock per port.
// Each port writes only its own bank, so no array has two writers.
// A one-bit tag per word and port records which bank is newest:
// the XOR of the two tags selects bank B when 1.
// Assumes: same-cycle writes of one word from both ports leave the word
// undefined; the array and the read registers carry no reset.
module dpr_xor_lane_ram #(
    parameter int ADDR_W = dpr_pkg::DEF_ADDR_W,
    parameter int LANE_W = dpr_pkg::DEF_LANE_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic              we_a,
    input  logic [LANE_W-1:0] wd_a,
    output logic [LANE_W-1:0] rd_a,
    input  logic              clk_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              we_b,
    input  logic [LANE_W-1:0] wd_b,
    output logic [LANE_W-1:0] rd_b
);

    logic [LANE_W-1:0] bank_a [DEPTH];
    logic [LANE_W-1:0] bank_b [DEPTH];
    logic              tag_a  [DEPTH];
    logic              tag_b  [DEPTH];

    // Port A: write own bank and make tags XOR to 0; read newest bank.
    always_ff @(posedge clk_a) begin
        if (we_a) begin
            bank_a[addr_a] <= wd_a;
            tag_a[addr_a]  <= tag_b[addr_a];
        end
        rd_a <= (tag_a[addr_a] ^ tag_b[addr_a]) ? bank_b[addr_a] : bank_a[addr_a];
    end

    // Port B: write own bank and make tags XOR to 1; read newest bank.
    always_ff @(posedge clk_b) begin
        if (we_b) begin
            bank_b[addr_b] <= wd_b;
            tag_b[addr_b]  <= ~tag_a[addr_b];
        end
        rd_b <= (tag_a[addr_b] ^ tag_b[addr_b]) ? bank_b[addr_b] : bank_a[addr_b];
    end

endmodule

// File: rtl/dpr_out_stage.sv
// Read output staging for one port. The lane enables of the request are
// delayed one cycle to line up with the array's read register; that is
// the flow-through result. A second register gives the pipelined one.
// Assumes: pipe is static or changes only between accesses.
module dpr_out_stage #(
    parameter int LANE_W = dpr_pkg::DEF_LANE_W,
    parameter int LANES  = dpr_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe,
    input  logic [LANES-1:0]  rd_lanes,
    input  logic [WORD_W-1:0] mem_q,
    output logic [WORD_W-1:0] rdata,
    output logic [LANES-1:0]  rdata_en
);
    import dpr_pkg::*;

    logic [LANES-1:0]  s1_en;
    logic [LANES-1:0]  s2_en;
    logic [WORD_W-1:0] flow_word;
    logic [WORD_W-1:0] s2_word;

    // Align the lane enables with the array read register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_en <= '0;
        end else begin
            s1_en <= rd_lanes;
        end
    end

    // Zero every lane that is not driven.
    for (genvar l = 0; l < LANES; l++) begin : g_mask
        assign flow_word[l*LANE_W +: LANE_W] = s1_en[l] ? mem_q[l*LANE_W +: LANE_W] : '0;
    end

    // Extra register stage for the pipelined mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_en   <= '0;
            s2_word <= '0;
        end else begin
            s2_en   <= s1_en;
            s2_word <= flow_word;
        end
    end

    // Pick the stage that the latency mode asks for.
    always_comb begin
        if (lat_mode_e'(pipe) == LAT_PIPE) begin
            rdata    = s2_word;
            rdata_en = s2_en;
        end else begin
            rdata    = flow_word;
            rdata_en = s1_en;
        end
    end

endmodule

// File: rtl/dpr_burst_ram.sv
// Top: dual-clock burst-addressed RAM with byte lanes.
// Two port front-ends, one dual-port storage slice per lane, and
// two output stages.
// Assumes: the two clocks are unrelated; each reset is synchronous to
// its own clock.
module dpr_burst_ram #(
    parameter int ADDR_W = dpr_pkg::DEF_ADDR_W,
    parameter int LANE_W = dpr_pkg::DEF_LANE_W,
    parameter int LANES  = dpr_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input  logic              clk_a,
    input  logic              rst_a_n,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic              ads_a_n,
    input  logic              cnt_en_a_n,
    input  logic              cnt_clr_a_n,
    input  logic              cs_a_n,
    input  logic              cs_a,
    input  logic              we_a_n,
    input  logic [LANES-1:0]  lane_a_n,
    input  logic              oe_a_n,
    input  logic              pipe_a,
    input  logic [WORD_W-1:0] wdata_a,
    output logic [WORD_W-1:0] rdata_a,
    output logic [LANES-1:0]  rdata_a_en,
    input  logic              clk_b,
    input  logic              rst_b_n,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic              ads_b_n,
    input  logic              cnt_en_b_n,
    input  logic              cnt_clr_b_n,
    input  logic              cs_b_n,
    input  logic              cs_b,
    input  logic              we_b_n,
    input  logic [LANES-1:0]  lane_b_n,
    input  logic              oe_b_n,
    input  logic              pipe_b,
    input  logic [WORD_W-1:0] wdata_b,
    output logic [WORD_W-1:0] rdata_b,
    output logic [LANES-1:0]  rdata_b_en
);

    logic [ADDR_W-1:0] cnt_a,  cnt_b;
    logic [LANES-1:0]  wr_a,   wr_b;
    logic [LANES-1:0]  rd_a,   rd_b;
    logic [WORD_W-1:0] wd_a,   wd_b;
    logic [WORD_W-1:0] q_a,    q_b;

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_ctrl_a (
        .clk(clk_a), .rst_n(rst_a_n), .addr(addr_a), .ads_n(ads_a_n),
        .cnt_en_n(cnt_en_a_n), .cnt_clr_n(cnt_clr_a_n), .cs_n(cs_a_n), .cs(cs_a),
        .we_n(we_a_n), .lane_n(lane_a_n), .oe_n(oe_a_n), .wdata(wdata_a),
        .cur_addr(cnt_a), .wr_lanes(wr_a), .rd_lanes(rd_a), .wr_data(wd_a)
    );

    dpr_port_ctrl #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_ctrl_b (
        .clk(clk_b), .rst_n(rst_b_n), .addr(addr_b), .ads_n(ads_b_n),
        .cnt_en_n(cnt_en_b_n), .cnt_clr_n(cnt_clr_b_n), .cs_n(cs_b_n), .cs(cs_b),
        .we_n(we_b_n), .lane_n(lane_b_n), .oe_n(oe_b_n), .wdata(wdata_b),
        .cur_addr(cnt_b), .wr_lanes(wr_b), .rd_lanes(rd_b), .wr_data(wd_b)
    );

    // One storage slice per lane; lane masking is a per-slice write enable.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        dpr_xor_lane_ram #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_ram (
            .clk_a(clk_a), .addr_a(cnt_a), .we_a(wr_a[l]),
            .wd_a(wd_a[l*LANE_W +: LANE_W]), .rd_a(q_a[l*LANE_W +: LANE_W]),
            .clk_b(clk_b), .addr_b(cnt_b), .we_b(wr_b[l]),
            .wd_b(wd_b[l*LANE_W +: LANE_W]), .rd_b(q_b[l*LANE_W +: LANE_W])
        );
    end

    dpr_out_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_out_a (
        .clk(clk_a), .rst_n(rst_a_n), .pipe(pipe_a), .rd_lanes(rd_a),
        .mem_q(q_a), .rdata(rdata_a), .rdata_en(rdata_a_en)
    );

    dpr_out_stage #(.LANE_W(LANE_W), .LANES(LANES)) u_out_b (
        .clk(clk_b), .rst_n(rst_b_n), .pipe(pipe_b), .rd_lanes(rd_b),
        .mem_q(q_b), .rdata(rdata_b), .rdata_en(rdata_b_en)
    );

endmodule

// File: rtl/dpr_burst_ram_chk.sv
// Property checker for dpr_burst_ram, attached by bind below.
// Assumes: the counters are visible as cnt_a / cnt_b in the top module.
module dpr_burst_ram_chk #(
    parameter int ADDR_W = dpr_pkg::DEF_ADDR_W,
    parameter int LANE_W = dpr_pkg::DEF_LANE_W,
    parameter int LANES  = dpr_pkg::DEF_LANES,
    localparam int WORD_W = LANE_W * LANES
) (
    input logic              clk_a,
    input logic              rst_a_n,
    input logic [ADDR_W-1:0] addr_a,
    input logic              ads_a_n,
    input logic              cnt_en_a_n,
    input logic              cnt_clr_a_n,
    input logic              cs_a_n,
    input logic              cs_a,
    input logic              pipe_a,
    input logic [WORD_W-1:0] rdata_a,
    input logic [LANES-1:0]  rdata_a_en,
    input logic [ADDR_W-1:0] cnt_a,
    input logic              clk_b,
    input logic              rst_b_n,
    input logic [ADDR_W-1:0] addr_b,
    input logic              ads_b_n,
    input logic              cnt_clr_b_n,
    input logic [ADDR_W-1:0] cnt_b
);

    logic [1:0]        age_a;
    logic [WORD_W-1:0] lane_mask_a;

    // Cycles since reset on port A, saturating at 3.
    always_ff @(posedge clk_a) begin
        if (!rst_a_n) begin
            age_a <= '0;
        end else if (age_a != 2'd3) begin
            age_a <= age_a + 1'b1;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_m
        assign lane_mask_a[l*LANE_W +: LANE_W] = {LANE_W{rdata_a_en[l]}};
    end

    a_r8_clear_a: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        !cnt_clr_a_n |=> cnt_a == '0);
    a_r6_load_a: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (cnt_clr_a_n && !ads_a_n) |=> cnt_a == $past(addr_a));
    a_r7_step_a: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (cnt_clr_a_n && ads_a_n && !cnt_en_a_n) |=> cnt_a == ADDR_W'($past(cnt_a) + 1'b1));
    a_r7_hold_a: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (cnt_clr_a_n && ads_a_n && cnt_en_a_n) |=> $stable(cnt_a));
    a_r9_wrap_a: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (cnt_clr_a_n && ads_a_n && !cnt_en_a_n && (&cnt_a)) |=> cnt_a == '0);
    a_r3_deselect_quiet_a: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (age_a == 2'd3 && !pipe_a && ($past(cs_a_n, 2) || !$past(cs_a, 2))) |-> rdata_a_en == '0);
    a_r10_idle_lane_zero_a: assert property (@(posedge clk_a) disable iff (!rst_a_n)
        (rdata_a_en != {LANES{1'b1}}) |-> (rdata_a & ~lane_mask_a) == '0);
    a_r8_clear_b: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        !cnt_clr_b_n |=> cnt_b == '0);
    a_r6_load_b: assert property (@(posedge clk_b) disable iff (!rst_b_n)
        (cnt_clr_b_n && !ads_b_n) |=> cnt_b == $past(addr_b));

endmodule

bind dpr_burst_ram dpr_burst_ram_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_chk (
    .clk_a(clk_a), .rst_a_n(rst_a_n), .addr_a(addr_a), .ads_a_n(ads_a_n),
    .cnt_en_a_n(cnt_en_a_n), .cnt_clr_a_n(cnt_clr_a_n), .cs_a_n(cs_a_n), .cs_a(cs_a),
    .pipe_a(pipe_a), .rdata_a(rdata_a), .rdata_a_en(rdata_a_en), .cnt_a(cnt_a),
    .clk_b(clk_b), .rst_b_n(rst_b_n), .addr_b(addr_b), .ads_b_n(ads_b_n),
    .cnt_clr_b_n(cnt_clr_b_n), .cnt_b(cnt_b)
);

// File: tb/dpr_burst_ram_bench.sv
// Bench: directed phases then a random mix, against a behavioural model.
module dpr_burst_ram_bench;

    localparam int AW = 4;
    localparam int NW = 16;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        i_rst_n  [2];
    logic [3:0]  i_addr   [2];
    logic        i_ads_n  [2];
    logic        i_cen_n  [2];
    logic        i_clr_n  [2];
    logic        i_cs_n   [2];
    logic        i_cs     [2];
    logic        i_we_n   [2];
    logic [1:0]  i_lane_n [2];
    logic        i_oe_n   [2];
    logic        i_pipe   [2];
    logic [17:0] i_wd     [2];
    logic [17:0] o_rd     [2];
    logic [1:0]  o_en     [2];

    dpr_burst_ram #(.ADDR_W(AW), .LANE_W(9), .LANES(2)) u_dpr_burst_ram (
        .clk_a(clk), .rst_a_n(i_rst_n[0]), .addr_a(i_addr[0]), .ads_a_n(i_ads_n[0]),
        .cnt_en_a_n(i_cen_n[0]), .cnt_clr_a_n(i_clr_n[0]), .cs_a_n(i_cs_n[0]), .cs_a(i_cs[0]),
        .we_a_n(i_we_n[0]), .lane_a_n(i_lane_n[0]), .oe_a_n(i_oe_n[0]), .pipe_a(i_pipe[0]),
        .wdata_a(i_wd[0]), .rdata_a(o_rd[0]), .rdata_a_en(o_en[0]),
        .clk_b(clk), .rst_b_n(i_rst_n[1]), .addr_b(i_addr[1]), .ads_b_n(i_ads_n[1]),
        .cnt_en_b_n(i_cen_n[1]), .cnt_clr_b_n(i_clr_n[1]), .cs_b_n(i_cs_n[1]), .cs_b(i_cs[1]),
        .we_b_n(i_we_n[1]), .lane_b_n(i_lane_n[1]), .oe_b_n(i_oe_n[1]), .pipe_b(i_pipe[1]),
        .wdata_b(i_wd[1]), .rdata_b(o_rd[1]), .rdata_b_en(o_en[1])
    );

    // Behavioural model state.
    logic [17:0] m_mem [NW];
    logic [1:0]  m_unk [NW];
    logic [3:0]  m_cnt [2];
    logic [1:0]  m_wr  [2];
    logic [1:0]  m_rd  [2];
    logic [17:0] m_wd  [2];
    logic [1:0]  f_en  [2], p_en  [2];
    logic [17:0] f_dat [2], p_dat [2];
    logic [1:0]  f_unk [2], p_unk [2];

    int    checks = 0;
    int    fails  = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    function automatic logic [17:0] widen(logic [1:0] m);
        return {{9{m[1]}}, {9{m[0]}}};
    endfunction

    // Model of one clock edge for both ports, using the inputs now applied.
    task automatic model_edge();
        logic [17:0] rdw [2];
        logic [1:0]  rdu [2];
        logic [1:0]  both;
        for (int p = 0; p < 2; p++) begin
            rdw[p] = m_mem[m_cnt[p]];
            rdu[p] = m_unk[m_cnt[p]];
            if (m_cnt[1-p] == m_cnt[p]) rdu[p] = rdu[p] | m_wr[1-p];
        end
        both = (m_cnt[0] == m_cnt[1]) ? (m_wr[0] & m_wr[1]) : 2'b00;
        for (int p = 0; p < 2; p++) begin
            m_mem[m_cnt[p]] = (m_mem[m_cnt[p]] & ~widen(m_wr[p])) | (m_wd[p] & widen(m_wr[p]));
            m_unk[m_cnt[p]] = m_unk[m_cnt[p]] & ~m_wr[p];
        end
        m_unk[m_cnt[0]] = m_unk[m_cnt[0]] | both;
        for (int p = 0; p < 2; p++) begin
            if (!i_rst_n[p]) begin
                p_en[p] = '0; p_dat[p] = '0; p_unk[p] = '0;
                f_en[p] = '0; f_dat[p] = '0; f_unk[p] = '0;
                m_cnt[p] = '0; m_wr[p] = '0; m_rd[p] = '0; m_wd[p] = '0;
            end else begin
                p_en[p] = f_en[p]; p_dat[p] = f_dat[p]; p_unk[p] = f_unk[p];
                f_en[p] = m_rd[p]; f_dat[p] = rdw[p] & widen(m_rd[p]); f_unk[p] = rdu[p];
                if (!i_clr_n[p])      m_cnt[p] = '0;
                else if (!i_ads_n[p]) m_cnt[p] = i_addr[p];
                else if (!i_cen_n[p]) m_cnt[p] = m_cnt[p] + 1'b1;
                m_wr[p] = (!i_cs_n[p] && i_cs[p] && !i_we_n[p]) ? ~i_lane_n[p] : 2'b00;
                m_rd[p] = (!i_cs_n[p] && i_cs[p] && i_we_n[p] && !i_oe_n[p]) ? ~i_lane_n[p] : 2'b00;
                m_wd[p] = i_wd[p];
            end
        end
    endtask

    // Compare one port's outputs with the model, away from the clock edge.
    task automatic check_port(int p);
        logic [1:0]  een;
        logic [17:0] edat;
        logic [1:0]  eunk;
        een  = i_pipe[p] ? p_en[p]  : f_en[p];
        edat = i_pipe[p] ? p_dat[p] : f_dat[p];
        eunk = i_pipe[p] ? p_unk[p] : f_unk[p];
        checks++;
        if (o_en[p] !== een) begin
            fails++;
            $display("FAIL %s port %0d lane enables: got %b expected %b", tag, p, o_en[p], een);
        end
        for (int l = 0; l < 2; l++) begin
            if (!een[l] || !eunk[l]) begin
                checks++;
                if (o_rd[p][l*9 +: 9] !== edat[l*9 +: 9]) begin
                    fails++;
                    $display("FAIL %s port %0d lane %0d data: got %h expected %h",
                             tag, p, l, o_rd[p][l*9 +: 9], edat[l*9 +: 9]);
                end
            end
        end
    endtask

    task automatic set_idle(int p);
        i_addr[p] = '0; i_ads_n[p] = 1'b1; i_cen_n[p] = 1'b1; i_clr_n[p] = 1'b1;
        i_cs_n[p] = 1'b0; i_cs[p] = 1'b1; i_we_n[p] = 1'b1; i_lane_n[p] = 2'b11;
        i_oe_n[p] = 1'b1; i_wd[p] = '0;
    endtask

    // One clock: apply, model the edge, compare at the falling edge, go idle.
    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_port(0);
        check_port(1);
        set_idle(0);
        set_idle(1);
    endtask

    task automatic wr(int p, bit ld, logic [3:0] a, bit step, logic [1:0] ln, logic [17:0] d);
        i_ads_n[p] = !ld; i_addr[p] = a; i_cen_n[p] = !step;
        i_we_n[p] = 1'b0; i_lane_n[p] = ln; i_wd[p] = d;
    endtask

    task automatic rd(int p, bit ld, logic [3:0] a, bit step, logic [1:0] ln);
        i_ads_n[p] = !ld; i_addr[p] = a; i_cen_n[p] = !step;
        i_we_n[p] = 1'b1; i_oe_n[p] = 1'b0; i_lane_n[p] = ln;
    endtask

    task automatic idle_cycles(int n);
        for (int k = 0; k < n; k++) cyc();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog (all requirements): got no completion expected end of stimulus");
            summary();
            $finish;
        end
    end

    initial begin
        for (int w = 0; w < NW; w++) begin
            m_mem[w] = '0;
            m_unk[w] = 2'b11;
        end
        for (int p = 0; p < 2; p++) begin
            set_idle(p);
            i_pipe[p] = 1'b0; i_rst_n[p] = 1'b0;
            m_cnt[p] = '0; m_wr[p] = '0; m_rd[p] = '0; m_wd[p] = '0;
            f_en[p] = '0; f_dat[p] = '0; f_unk[p] = '0;
            p_en[p] = '0; p_dat[p] = '0; p_unk[p] = '0;
        end
        @(negedge clk);

        // R1: reset leaves outputs quiet.
        tag = "R1";
        idle_cycles(3);
        i_rst_n[0] = 1'b1; i_rst_n[1] = 1'b1;
        idle_cycles(2);

        // R2: lane-masked write keeps the masked lane.
        tag = "R2";
        wr(0, 1, 4'd2, 0, 2'b00, 18'h3FFFF); cyc();
        wr(0, 1, 4'd2, 0, 2'b10, 18'h00000); cyc();
        rd(0, 1, 4'd2, 0, 2'b00); cyc();
        idle_cycles(2);

        // R6 and R4: load then flow-through read one edge after registration.
        tag = "R6";
        wr(0, 1, 4'd9, 0, 2'b00, 18'h2A5A5); cyc();
        tag = "R4";
        rd(0, 1, 4'd9, 0, 2'b00); cyc();
        idle_cycles(2);

        // R7: burst write with stepping, burst read, then a hold.
        tag = "R7";
        wr(0, 1, 4'd5, 0, 2'b00, 18'h00100); cyc();
        wr(0, 0, 4'd0, 1, 2'b00, 18'h00101); cyc();
        wr(0, 0, 4'd0, 1, 2'b00, 18'h00102); cyc();
        rd(0, 1, 4'd5, 0, 2'b00); cyc();
        rd(0, 0, 4'd0, 1, 2'b00); cyc();
        rd(0, 0, 4'd0, 1, 2'b00); cyc();
        rd(0, 0, 4'd0, 0, 2'b00); cyc();
        idle_cycles(2);

        // R5: the same burst read in pipelined mode.
        tag = "R5";
        i_pipe[0] = 1'b1;
        idle_cycles(1);
        rd(0, 1, 4'd5, 0, 2'b00); cyc();
        rd(0, 0, 4'd0, 1, 2'b00); cyc();
        rd(0, 0, 4'd0, 1, 2'b00); cyc();
        idle_cycles(3);
        i_pipe[0] = 1'b0;
        idle_cycles(1);

        // R8: clear outranks load.
        tag = "R8";
        wr(0, 1, 4'd0, 0, 2'b00, 18'h11111); cyc();
        rd(0, 1, 4'd7, 1, 2'b00); i_clr_n[0] = 1'b0; cyc();
        idle_cycles(2);

        // R9: stepping past the top address wraps to zero.
        tag = "R9";
        wr(0, 1, 4'd14, 0, 2'b00, 18'h0E0E0); cyc();
        wr(0, 0, 4'd0, 1, 2'b00, 18'h0F0F0); cyc();
        wr(0, 0, 4'd0, 1, 2'b00, 18'h12345); cyc();
        rd(0, 1, 4'd15, 0, 2'b00); cyc();
        rd(0, 0, 4'd0, 1, 2'b00); cyc();
        idle_cycles(2);

        // R3: deselected writes have no effect, deselected reads stay quiet.
        tag = "R3";
        wr(0, 1, 4'd2, 0, 2'b00, 18'h01234); i_cs_n[0] = 1'b1; cyc();
        wr(0, 1, 4'd2, 0, 2'b00, 18'h04321); i_cs[0] = 1'b0; cyc();
        rd(0, 1, 4'd2, 0, 2'b00); i_cs[0] = 1'b0; cyc();
        rd(0, 1, 4'd2, 0, 2'b00); cyc();
        idle_cycles(2);

        // R10: output enable and per-lane read enables.
        tag = "R10";
        rd(0, 1, 4'd9, 0, 2'b00); i_oe_n[0] = 1'b1; cyc();
        rd(0, 1, 4'd9, 0, 2'b01); cyc();
        rd(0, 1, 4'd9, 0, 2'b10); cyc();
        idle_cycles(2);

        // R11: cross-port visibility, both ports busy at once.
        tag = "R11";
        wr(1, 1, 4'd11, 0, 2'b00, 18'h3C3C3); wr(0, 1, 4'd12, 0, 2'b00, 18'h15A5A); cyc();
        rd(0, 1, 4'd11, 0, 2'b00); rd(1, 1, 4'd12, 0, 2'b00); cyc();
        i_pipe[1] = 1'b1;
        rd(1, 1, 4'd11, 0, 2'b00); cyc();
        idle_cycles(3);

        // R11 and R2: random mix on both ports; collisions are don't-care.
        for (int n = 0; n < 600; n++) begin
            for (int p = 0; p < 2; p++) begin
                if (n % 64 == 0) i_pipe[p] = 1'($urandom % 2);
                i_clr_n[p]  = ($urandom % 16) != 0;
                i_ads_n[p]  = ($urandom % 4) != 0;
                i_cen_n[p]  = 1'($urandom % 2);
                i_addr[p]   = 4'($urandom);
                i_cs_n[p]   = ($urandom % 8) == 0;
                i_cs[p]     = ($urandom % 8) != 0;
                i_we_n[p]   = ($urandom % 3) != 0;
                i_lane_n[p] = 2'($urandom);
                i_oe_n[p]   = ($urandom % 5) == 0;
                i_wd[p]     = 18'($urandom);
            end
            cyc();
        end
        idle_cycles(3);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule